// File: doc/BRIEF.md
# SDRAM Single-Access Command Sequencer

This block turns one read or write request at a time into the command stream that an SDR SDRAM with four internal banks expects. A requester presents a bank, row, column, 32-bit write word and 4-bit byte mask, then holds `req_valid` high. The sequencer opens the row with an activate, waits a programmable row-to-column delay, issues the column read or write, closes the bank with a precharge to all banks, and waits the precharge recovery time. It then pulses `req_ack` for one cycle.

Commands are not coded words on a bus. Each one is a level pattern on chip select, row strobe, column strobe and write enable, and all four are registered. The 32-bit data path belongs to two 16-bit devices and has one mask line per byte. On writes the mask goes out in the same cycle as the data. On reads it trails the command by two cycles. Read data comes back after the CAS latency on `sd_dq_in`. Bytes that the request masked are forced to zero in `rd_data`, and `rd_valid` is high for that one cycle.

Top module: `sdr_seq`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it, the command lines carry NOP ({cs_n,ras_n,cas_n,we_n} = 0111), and `sd_dq_oe`, `sd_dqm`, `req_ack` and `rd_valid` are all zero.
- R2: When idle, the sequencer accepts `req_valid` at a clock edge. In the next cycle it drives ACTIVE (0011) with `sd_ba` equal to the request bank and `sd_addr` equal to the request row.
- R3: Between ACTIVE and the column command it drives exactly T_RCD-1 NOP cycles, so the column command comes T_RCD cycles after ACTIVE.
- R4: The column command is READ (0101) or WRITE (0100), selected by `req_write`. It carries the request column on the low `sd_addr` bits, address bit 10 low, and the request bank on `sd_ba`.
- R5: `sd_dq_oe` is high only in the WRITE cycle. In that cycle `sd_dq_out` holds the write word and `sd_dqm` holds the request mask (bit i masks byte i, bits 8i+7..8i).
- R6: For a read, `sd_dqm` holds the request mask exactly two cycles after the READ cycle. Outside that cycle and the WRITE cycle, `sd_dqm` is zero.
- R7: `rd_valid` is high for one cycle, CAS_LAT cycles after READ. In that cycle `rd_data` equals `sd_dq_in` with every byte whose mask bit is set forced to zero.
- R8: PRECHARGE (0010) with `sd_addr[10]` high follows in the cycle directly after the column command.
- R9: After PRECHARGE there are T_RP-1 NOP cycles, then one NOP cycle with `req_ack` high. `req_valid` is not taken in the ack cycle, so the next cycle is NOP as well.
- R10: Request fields are sampled only at acceptance. Changing them during the access does not alter the bank, column, write data or masks driven later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present, held until the cycle after `req_ack` |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | 2 | Bank index |
| req_row | input | ROW_W | Row address |
| req_col | input | COL_W | Column address |
| req_wdata | input | DQ_W | Write word |
| req_mask | input | DQ_W/8 | Byte mask, 1 = byte blocked |
| req_ack | output | 1 | One-cycle completion pulse |
| rd_data | output | DQ_W | Masked read word |
| rd_valid | output | 1 | Read data strobe |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank address |
| sd_addr | output | ADDR_W | Multiplexed row/column address |
| sd_dqm | output | DQ_W/8 | Per-byte data mask |
| sd_dq_out | output | DQ_W | Data driven toward memory |
| sd_dq_oe | output | 1 | Output enable for `sd_dq_out` |
| sd_dq_in | input | DQ_W | Data returned from memory |

## Verification
A stuck or miscounting state counter shows up on the command lines within one access. The column command or the precharge lands a cycle early or late, or `req_ack` never rises. A wrong latch of the request shows as a bad bank, column, data word or mask in the cycle that uses it. A wrong read pipeline depth moves `rd_valid` or the read mask by a cycle, which shows within CAS_LAT cycles of the READ. The bench sweeps every bank and every mask value for both directions and compares each bus cycle of each access against a cycle-indexed expectation.

// File: rtl/sdr_seq_pkg.sv
package sdr_seq_pkg;

    // {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_NOP = 4'b0111,
        CMD_ACT = 4'b0011,
        CMD_RD  = 4'b0101,
        CMD_WR  = 4'b0100,
        CMD_PRE = 4'b0010
    } sdr_cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RCD,
        ST_PRE,
        ST_RP
    } seq_state_e;

endpackage

// File: rtl/sdr_seq_ctrl.sv
module sdr_seq_ctrl
    import sdr_seq_pkg::*;
#(
    parameter int ROW_W  = 13,
    parameter int COL_W  = 9,
    parameter int ADDR_W = 13,
    parameter int DQ_W   = 32,
    parameter int MASK_W = 4,
    parameter int T_RCD  = 2,
    parameter int T_RP   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    input  logic [DQ_W-1:0]   req_wdata,
    input  logic [MASK_W-1:0] req_mask,
    output sdr_cmd_e          cmd,
    output logic [1:0]        ba,
    output logic [ADDR_W-1:0] addr,
    output logic              dq_oe,
    output logic [DQ_W-1:0]   dq_out,
    output logic [MASK_W-1:0] wr_dqm,
    output logic [MASK_W-1:0] req_mask_held,
    output logic              ack
);

    localparam int T_MAX = (T_RCD > T_RP) ? T_RCD : T_RP;
    localparam int CNT_W = $clog2(T_MAX + 1);

    typedef struct packed {
        seq_state_e        st;
        logic [CNT_W-1:0]  cnt;
        logic              wr;
        logic [1:0]        bank;
        logic [COL_W-1:0]  col;
        logic [DQ_W-1:0]   wdata;
        logic [MASK_W-1:0] mask;
        sdr_cmd_e          cmd;
        logic [1:0]        ba;
        logic [ADDR_W-1:0] addr;
        logic              oe;
        logic [DQ_W-1:0]   dq;
        logic [MASK_W-1:0] wdqm;
        logic              ack;
    } ctrl_s;

    ctrl_s q, d;

    always_comb begin
        d      = q;
        d.cmd  = CMD_NOP;
        d.oe   = 1'b0;
        d.dq   = '0;
        d.wdqm = '0;
        d.ack  = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (req_valid && !q.ack) begin
                    d.wr    = req_write;
                    d.bank  = req_bank;
                    d.col   = req_col;
                    d.wdata = req_wdata;
                    d.mask  = req_mask;
                    d.cmd   = CMD_ACT;
                    d.ba    = req_bank;
                    d.addr  = ADDR_W'(req_row);
                    d.cnt   = CNT_W'(T_RCD - 1);
                    d.st    = ST_RCD;
                end
            end
            ST_RCD: begin
                if (q.cnt == '0) begin
                    d.cmd  = q.wr ? CMD_WR : CMD_RD;
                    d.ba   = q.bank;
                    d.addr = ADDR_W'(q.col);
                    if (q.wr) begin
                        d.oe   = 1'b1;
                        d.dq   = q.wdata;
                        d.wdqm = q.mask;
                    end
                    d.st = ST_PRE;
                end else begin
                    d.cnt = q.cnt - CNT_W'(1);
                end
            end
            ST_PRE: begin
                d.cmd      = CMD_PRE;
                d.addr     = '0;
                d.addr[10] = 1'b1;
                d.cnt      = CNT_W'(T_RP - 1);
                d.st       = ST_RP;
            end
            default: begin
                if (q.cnt == '0) begin
                    d.ack = 1'b1;
                    d.st  = ST_IDLE;
                end else begin
                    d.cnt = q.cnt - CNT_W'(1);
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q     <= '0;
            q.st  <= ST_IDLE;
            q.cmd <= CMD_NOP;
        end else begin
            q <= d;
        end
    end

    assign cmd           = q.cmd;
    assign ba            = q.ba;
    assign addr          = q.addr;
    assign dq_oe         = q.oe;
    assign dq_out        = q.dq;
    assign wr_dqm        = q.wdqm;
    assign req_mask_held = q.mask;
    assign ack           = q.ack;

    // Checker state: open-row flag and cycles since the last activate
    logic             row_open_q;
    logic [CNT_W:0]   gap_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_open_q <= 1'b0;
            gap_q      <= '0;
        end else begin
            if (q.cmd == CMD_ACT)      row_open_q <= 1'b1;
            else if (q.cmd == CMD_PRE) row_open_q <= 1'b0;
            if (q.cmd == CMD_ACT)      gap_q <= (CNT_W+1)'(1);
            else if (gap_q != '1)      gap_q <= gap_q + (CNT_W+1)'(1);
        end
    end

    AST_COL_NEEDS_OPEN_ROW: assert property (@(posedge clk) disable iff (!rst_n)
        (q.cmd == CMD_RD || q.cmd == CMD_WR) |-> row_open_q); // R2

    AST_TRCD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (q.cmd == CMD_RD || q.cmd == CMD_WR) |-> (int'(gap_q) >= T_RCD)); // R3

    AST_COL_THEN_PRE: assert property (@(posedge clk) disable iff (!rst_n)
        (q.cmd == CMD_RD || q.cmd == CMD_WR) |=> (q.cmd == CMD_PRE)); // R8

endmodule

// File: rtl/sdr_seq_rdpath.sv
module sdr_seq_rdpath #(
    parameter int DQ_W    = 32,
    parameter int MASK_W  = 4,
    parameter int CAS_LAT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_issue,
    input  logic [MASK_W-1:0] rd_mask,
    input  logic [DQ_W-1:0]   sd_dq_in,
    output logic [MASK_W-1:0] rd_dqm,
    output logic              rd_valid,
    output logic [DQ_W-1:0]   rd_data
);

    localparam int DQM_LAG = 2;

    typedef struct packed {
        logic [CAS_LAT-1:0] vld;
        logic [MASK_W-1:0]  m1;
        logic [MASK_W-1:0]  m2;
    } rdp_s;

    rdp_s q, d;

    always_comb begin
        d     = q;
        d.vld = {q.vld[CAS_LAT-2:0], rd_issue};
        d.m1  = rd_issue ? rd_mask : '0;
        d.m2  = q.m1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    logic [DQ_W-1:0] keep;
    for (genvar b = 0; b < MASK_W; b++) begin : g_keep
        assign keep[b*8 +: 8] = {8{~rd_mask[b]}};
    end

    assign rd_dqm   = q.m2;
    assign rd_valid = q.vld[CAS_LAT-1];
    assign rd_data  = rd_valid ? (sd_dq_in & keep) : '0;

    AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(rd_issue, CAS_LAT)); // R7

    AST_RD_DQM_LAG: assert property (@(posedge clk) disable iff (!rst_n)
        (|rd_dqm) |-> $past(rd_issue, DQM_LAG)); // R6

endmodule

// File: rtl/sdr_seq.sv
module sdr_seq
    import sdr_seq_pkg::*;
#(
    parameter int ROW_W   = 13,
    parameter int COL_W   = 9,
    parameter int DQ_W    = 32,
    parameter int T_RCD   = 2,
    parameter int T_RP    = 2,
    parameter int CAS_LAT = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [1:0]           req_bank,
    input  logic [ROW_W-1:0]     req_row,
    input  logic [COL_W-1:0]     req_col,
    input  logic [DQ_W-1:0]      req_wdata,
    input  logic [DQ_W/8-1:0]    req_mask,
    output logic                 req_ack,
    output logic [DQ_W-1:0]      rd_data,
    output logic                 rd_valid,
    output logic                 sd_cs_n,
    output logic                 sd_ras_n,
    output logic                 sd_cas_n,
    output logic                 sd_we_n,
    output logic [1:0]           sd_ba,
    output logic [((ROW_W > 11) ? ROW_W : 11)-1:0] sd_addr,
    output logic [DQ_W/8-1:0]    sd_dqm,
    output logic [DQ_W-1:0]      sd_dq_out,
    output logic                 sd_dq_oe,
    input  logic [DQ_W-1:0]      sd_dq_in
);

    localparam int MASK_W = DQ_W / 8;
    localparam int ADDR_W = (ROW_W > 11) ? ROW_W : 11;

    sdr_cmd_e          cmd;
    logic [MASK_W-1:0] wr_dqm;
    logic [MASK_W-1:0] rd_dqm;
    logic [MASK_W-1:0] mask_held;

    sdr_seq_ctrl #(
        .ROW_W (ROW_W), .COL_W (COL_W), .ADDR_W (ADDR_W), .DQ_W (DQ_W),
        .MASK_W(MASK_W), .T_RCD (T_RCD), .T_RP  (T_RP)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_write    (req_write),
        .req_bank     (req_bank),
        .req_row      (req_row),
        .req_col      (req_col),
        .req_wdata    (req_wdata),
        .req_mask     (req_mask),
        .cmd          (cmd),
        .ba           (sd_ba),
        .addr         (sd_addr),
        .dq_oe        (sd_dq_oe),
        .dq_out       (sd_dq_out),
        .wr_dqm       (wr_dqm),
        .req_mask_held(mask_held),
        .ack          (req_ack)
    );

    sdr_seq_rdpath #(
        .DQ_W(DQ_W), .MASK_W(MASK_W), .CAS_LAT(CAS_LAT)
    ) u_rdpath (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_issue(cmd == CMD_RD),
        .rd_mask (mask_held),
        .sd_dq_in(sd_dq_in),
        .rd_dqm  (rd_dqm),
        .rd_valid(rd_valid),
        .rd_data (rd_data)
    );

    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;
    assign sd_dqm = wr_dqm | rd_dqm;

    AST_OE_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        sd_dq_oe |-> ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0100)); // R5

    AST_PRE_ALL_BANKS: assert property (@(posedge clk) disable iff (!rst_n)
        ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0010) |-> sd_addr[10]); // R8

    AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |=> !req_ack); // R9

    AST_NO_ACT_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |=> ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111)); // R9

endmodule

// File: tb/tb_sdr_seq.sv
module tb_sdr_seq;

    localparam int ROW_W = 13, COL_W = 9, DQ_W = 32, MW = 4, AW = 13;
    localparam int TRCD = 2, TRP = 2, CL = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic             req_valid = 1'b0, req_write = 1'b0;
    logic [1:0]       req_bank = '0;
    logic [ROW_W-1:0] req_row = '0;
    logic [COL_W-1:0] req_col = '0;
    logic [DQ_W-1:0]  req_wdata = '0;
    logic [MW-1:0]    req_mask = '0;
    logic             req_ack, rd_valid;
    logic [DQ_W-1:0]  rd_data, sd_dq_out;
    logic             sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe;
    logic [1:0]       sd_ba;
    logic [AW-1:0]    sd_addr;
    logic [MW-1:0]    sd_dqm;
    logic [DQ_W-1:0]  sd_dq_in = '0;

    sdr_seq #(.ROW_W(ROW_W), .COL_W(COL_W), .DQ_W(DQ_W),
              .T_RCD(TRCD), .T_RP(TRP), .CAS_LAT(CL)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
        .req_wdata(req_wdata), .req_mask(req_mask), .req_ack(req_ack),
        .rd_data(rd_data), .rd_valid(rd_valid), .sd_cs_n(sd_cs_n),
        .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
        .sd_ba(sd_ba), .sd_addr(sd_addr), .sd_dqm(sd_dqm),
        .sd_dq_out(sd_dq_out), .sd_dq_oe(sd_dq_oe), .sd_dq_in(sd_dq_in));

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] bus_cmd();
        return {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
    endfunction

    task automatic run_txn(input bit wr, input logic [1:0] bank,
                           input logic [ROW_W-1:0] row, input logic [COL_W-1:0] col,
                           input logic [DQ_W-1:0] wd, input logic [MW-1:0] m,
                           input logic [DQ_W-1:0] pat);
        int c_col, c_pre, c_ack;
        logic [DQ_W-1:0] exp_rd;
        c_col = 1 + TRCD;
        c_pre = c_col + 1;
        c_ack = c_pre + TRP;
        for (int b = 0; b < MW; b++) exp_rd[b*8 +: 8] = m[b] ? 8'h00 : pat[b*8 +: 8];
        @(negedge clk);
        req_write = wr; req_bank = bank; req_row = row; req_col = col;
        req_wdata = wd; req_mask = m; sd_dq_in = pat; req_valid = 1'b1;
        for (int k = 1; k <= c_ack; k++) begin
            @(negedge clk);
            if (k == 1) begin
                chk("R2 cmd ACTIVE", 64'(bus_cmd()), 64'(4'b0011));
                chk("R2 bank", 64'(sd_ba), 64'(bank));
                chk("R2 row", 64'(sd_addr), 64'(row));
                // scramble the request: must not leak into later cycles
                req_write = ~wr; req_bank = ~bank; req_col = ~col;
                req_wdata = ~wd; req_mask = ~m; req_row = ~row;
            end else if (k == c_col) begin
                chk("R4 cmd column", 64'(bus_cmd()), wr ? 64'(4'b0100) : 64'(4'b0101));
                chk("R10 column addr", 64'(sd_addr), 64'(col));
                chk("R10 column bank", 64'(sd_ba), 64'(bank));
            end else if (k == c_pre) begin
                chk("R8 cmd PRECHARGE", 64'(bus_cmd()), 64'(4'b0010));
                chk("R8 addr bit 10", 64'(sd_addr[10]), 64'(1'b1));
            end else begin
                chk(k < c_col ? "R3 NOP in tRCD" : "R9 NOP in tRP",
                    64'(bus_cmd()), 64'(4'b0111));
            end
            chk("R5 dq_oe", 64'(sd_dq_oe), 64'(wr && k == c_col));
            if (wr && k == c_col) chk("R5 R10 write data", 64'(sd_dq_out), 64'(wd));
            chk(wr ? "R5 write dqm" : "R6 read dqm", 64'(sd_dqm),
                64'(((wr && k == c_col) || (!wr && k == c_col + 2)) ? m : 4'h0));
            chk("R7 rd_valid", 64'(rd_valid), 64'(!wr && k == c_col + CL));
            if (!wr && k == c_col + CL) chk("R7 read data", 64'(rd_data), 64'(exp_rd));
            chk("R9 req_ack", 64'(req_ack), 64'(k == c_ack));
        end
        @(negedge clk);
        chk("R9 no accept in ack cycle", 64'(bus_cmd()), 64'(4'b0111));
        chk("R9 ack low again", 64'(req_ack), 64'(1'b0));
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset cmd", 64'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}), 64'(4'b0111));
        chk("R1 reset oe", 64'(sd_dq_oe), 64'(0));
        chk("R1 reset dqm", 64'(sd_dqm), 64'(0));
        chk("R1 reset ack", 64'(req_ack), 64'(0));
        chk("R1 reset rd_valid", 64'(rd_valid), 64'(0));
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle cmd after reset", 64'(bus_cmd()), 64'(4'b0111));
        begin
            int i;
            i = 0;
            for (int op = 0; op < 2; op++)
                for (int bk = 0; bk < 4; bk++)
                    for (int m = 0; m < 16; m++) begin
                        run_txn(op[0], bk[1:0],
                                ROW_W'((i * 97 + 5) % (1 << ROW_W)),
                                COL_W'((i * 29 + 3) % (1 << COL_W)),
                                32'h1357_9BDF ^ (32'(i) * 32'h0101_0101),
                                m[3:0],
                                32'hA5C3_0F69 + 32'(i) * 32'h0001_1111);
                        i++;
                    end
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=<100000 cycles", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule